// File: doc/BRIEF.md
# Accumulator Processor Core (24-bit word, 20-bit address)

This block is a small multicycle processor built around one accumulator. It reads its instructions and data from a single-port synchronous memory. Data words are 24 bits wide and addresses are 20 bits wide. The core keeps five registers: the accumulator, the instruction address, a return address, a stack pointer and a frame pointer. Each instruction goes through fetch, decode and execute in sequence. An instruction that needs memory data takes extra read cycles. The instruction address moves on by one after each instruction unless that instruction loads it with a new value.

The memory behaves as follows. The core drives an address, a write enable and write data. A read returns data on the clock edge after the address was presented. A write takes effect at the edge where the write enable is high.

Execution stops for one of three causes, and the stop is sticky until reset:
- a halt instruction runs;
- an instruction word cannot be decoded;
- an instruction that leaves the instruction address alone retires at the top address.

When the core stops, it raises a stopped flag and reports the cause as a 2-bit code.

Top module: `acc_core`

## Requirements
- R1: A synchronous active-low reset clears all registers and the stop state. The first fetch after reset reads address 0. While in reset the core is not stopped and issues no write.
- R2: An instruction with major code 0x0 (bits 23-20) loads its 20-bit operand (bits 19-0) into the accumulator and clears bits 23-20. Major code 0x1 loads the accumulator from the word at the operand address. Major code 0x2 stores the accumulator at the operand address.
- R3: Major codes 0x3 to 0x6 combine the accumulator with the word at the operand address and write the result back: 0x3 is an add modulo 2^24, 0x4 is AND, 0x5 is OR and 0x6 is XOR. Major code 0x7 sets the accumulator to all ones when it equals that word, and to zero otherwise.
- R4: When bits 23-20 are 0xF, bits 23-16 form the code. 0xF1 inverts the accumulator. 0xF2 rotates it right by one, so bit 0 moves into bit 23. 0xFA adds bits 15-0, sign-extended to 24 bits.
- R5: Major code 0x8 loads the instruction address with the operand. Major code 0x9 does the same only when accumulator bit 23 is set; otherwise execution continues with the next word.
- R6: Major code 0xC writes the address of the following instruction into the return address and then jumps to the operand. 0xF3 loads the instruction address from the low 20 bits of the return address. 0xF8 copies the return address into the accumulator, and 0xF9 copies the accumulator into the return address.
- R7: 0xF4 and 0xF6 copy the stack pointer and the frame pointer into the accumulator. 0xF5 and 0xF7 copy the accumulator into them. Major codes 0xD (load) and 0xE (store) use as their address the stack pointer plus the operand, truncated to 20 bits.
- R8: Major codes 0xA (load) and 0xB (store) read the word at the operand address. They then use its bits 19-0 as the address of the actual access, and ignore bits 23-20.
- R9: Code 0xF0 stops the core with reason 0.
- R10: A code from 0xFB to 0xFF stops the core with reason 1 (undecodable word).
- R11: An instruction at address 0xFFFFF that does not load the instruction address stops the core with reason 2. A jump executed at 0xFFFFF does not stop the core.
- R12: Once stopped, the core keeps its flag and reason and issues no memory write until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | 20 | Memory address for the read or write of this cycle |
| mem_wdata | output | 24 | Data written when mem_we is high |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 24 | Read data for the address presented one cycle earlier |
| halted | output | 1 | High once execution has stopped |
| halt_reason | output | 2 | Stop cause: 0 halt instruction, 1 undecodable word, 2 address overflow |

## Verification
The assertions assume that the memory honours the one-cycle read latency. They also assume that reset is held low long enough to take effect at a clock edge before any program runs. The bench memory model returns registered read data on every edge. Programs are loaded only while reset is held, so no instruction is fetched before its word is in place. Every program ends in a halt instruction or a deliberate stop, so each run reaches the stopped state within a bounded number of cycles.

// File: rtl/acc_pkg.sv
// Package: shared widths, operation codes, sequencer states and stop reasons
// for the accumulator core. Assumes a 24-bit word with an 8-bit long opcode.
package acc_pkg;
    localparam int WORD_W_DEF = 24;
    localparam int ADDR_W_DEF = 20;
    localparam int MAJOR_W    = 4;
    localparam int MINOR_W    = 8;

    localparam logic [1:0] STOP_HALT    = 2'd0;
    localparam logic [1:0] STOP_ILLEGAL = 2'd1;
    localparam logic [1:0] STOP_WRAP    = 2'd2;

    typedef enum logic [4:0] {
        OP_LDC, OP_LDV, OP_STV, OP_ADD, OP_AND, OP_OR, OP_XOR, OP_EQL,
        OP_JMP, OP_JMN, OP_LDIV, OP_STIV, OP_CALL, OP_LDVR, OP_STVR,
        OP_HALT, OP_NOT, OP_RAR, OP_RET, OP_LDSP, OP_STSP, OP_LDFP,
        OP_STFP, OP_LDRA, OP_STRA, OP_ADC, OP_BAD
    } op_e;

    typedef enum logic [2:0] {
        ST_FETCH, ST_LOAD, ST_EXEC, ST_PTR, ST_DATA, ST_STOP
    } state_e;
endpackage

// File: rtl/acc_decode.sv
// Module: acc_decode
// Maps the top byte of an instruction word to an operation. The top nibble
// is the opcode unless it is all ones, in which case the whole byte is.
// Assumes a valid byte; unused long codes come out as OP_BAD.
module acc_decode import acc_pkg::*; (
    input  logic [MINOR_W-1:0] code,
    output op_e                op
);
    localparam int LOW_W = MINOR_W - MAJOR_W;

    // Two-level decode: short opcodes first, then the 0xF-prefixed group.
    always_comb begin
        case (code[MINOR_W-1 -: MAJOR_W])
            4'h0: op = OP_LDC;
            4'h1: op = OP_LDV;
            4'h2: op = OP_STV;
            4'h3: op = OP_ADD;
            4'h4: op = OP_AND;
            4'h5: op = OP_OR;
            4'h6: op = OP_XOR;
            4'h7: op = OP_EQL;
            4'h8: op = OP_JMP;
            4'h9: op = OP_JMN;
            4'hA: op = OP_LDIV;
            4'hB: op = OP_STIV;
            4'hC: op = OP_CALL;
            4'hD: op = OP_LDVR;
            4'hE: op = OP_STVR;
            default: begin
                case (code[LOW_W-1:0])
                    4'h0: op = OP_HALT;
                    4'h1: op = OP_NOT;
                    4'h2: op = OP_RAR;
                    4'h3: op = OP_RET;
                    4'h4: op = OP_LDSP;
                    4'h5: op = OP_STSP;
                    4'h6: op = OP_LDFP;
                    4'h7: op = OP_STFP;
                    4'h8: op = OP_LDRA;
                    4'h9: op = OP_STRA;
                    4'hA: op = OP_ADC;
                    default: op = OP_BAD;
                endcase
            end
        endcase
    end
endmodule

// File: rtl/acc_alu.sv
// Module: acc_alu
// Computes the new accumulator value for constant, memory and register-only
// operations. Purely combinational; the caller selects when to use it.
// Assumes mval holds the memory word only for operations that read one.
module acc_alu import acc_pkg::*; #(
    parameter  int WORD_W  = WORD_W_DEF,
    parameter  int ADDR_W  = ADDR_W_DEF,
    localparam int SHORT_W = WORD_W - MINOR_W
) (
    input  op_e               op,
    input  logic [WORD_W-1:0] acc,
    input  logic [WORD_W-1:0] mval,
    input  logic [ADDR_W-1:0] konst,
    input  logic [SHORT_W-1:0] short_imm,
    output logic [WORD_W-1:0] y
);
    // Result selection per operation.
    always_comb begin
        case (op)
            OP_LDC:  y = {{(WORD_W-ADDR_W){1'b0}}, konst};
            OP_LDV, OP_LDIV, OP_LDVR: y = mval;
            OP_ADD:  y = acc + mval;
            OP_AND:  y = acc & mval;
            OP_OR:   y = acc | mval;
            OP_XOR:  y = acc ^ mval;
            OP_EQL:  y = (acc == mval) ? '1 : '0;
            OP_NOT:  y = ~acc;
            OP_RAR:  y = {acc[0], acc[WORD_W-1:1]};
            OP_ADC:  y = acc + {{(WORD_W-SHORT_W){short_imm[SHORT_W-1]}}, short_imm};
            default: y = acc;
        endcase
    end
endmodule

// File: rtl/acc_core.sv
// Module: acc_core (top)
// Multicycle accumulator processor. Each instruction takes fetch, load and
// execute cycles, plus pointer and data cycles when it reads memory. Assumes
// a synchronous memory returning read data one edge after the address.
module acc_core import acc_pkg::*; #(
    parameter  int WORD_W  = WORD_W_DEF,
    parameter  int ADDR_W  = ADDR_W_DEF,
    localparam int SHORT_W = WORD_W - MINOR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              mem_we,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              halted,
    output logic [1:0]        halt_reason
);
    state_e            state, st_nxt;
    logic [WORD_W-1:0] ir, acc, ra, sp, fp;
    logic [ADDR_W-1:0] iar, iar_inc, operand, rel_addr, jmp_tgt;
    logic [1:0]        reason, stop_code;
    logic [WORD_W-1:0] alu_y, acc_nxt;
    logic              fin, jmp_en, acc_we, stop_en;
    op_e               op;

    assign operand  = ir[ADDR_W-1:0];
    assign rel_addr = sp[ADDR_W-1:0] + operand;
    assign iar_inc  = iar + 1'b1;
    assign halted      = (state == ST_STOP);
    assign halt_reason = reason;

    acc_decode u_dec (
        .code (ir[WORD_W-1 -: MINOR_W]),
        .op   (op)
    );

    acc_alu #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_alu (
        .op        (op),
        .acc       (acc),
        .mval      (mem_rdata),
        .konst     (operand),
        .short_imm (ir[SHORT_W-1:0]),
        .y         (alu_y)
    );

    // Memory request for the current sequencer state.
    always_comb begin
        mem_addr  = iar;
        mem_we    = 1'b0;
        mem_wdata = acc;
        if (state == ST_EXEC) begin
            case (op)
                OP_LDV, OP_ADD, OP_AND, OP_OR, OP_XOR, OP_EQL,
                OP_LDIV, OP_STIV: mem_addr = operand;
                OP_LDVR: mem_addr = rel_addr;
                OP_STV:  begin mem_addr = operand;  mem_we = 1'b1; end
                OP_STVR: begin mem_addr = rel_addr; mem_we = 1'b1; end
                default: mem_addr = iar;
            endcase
        end else if (state == ST_PTR) begin
            mem_addr = mem_rdata[ADDR_W-1:0];
            mem_we   = (op == OP_STIV);
        end
    end

    // Sequencing, retire decision and stop detection.
    always_comb begin
        st_nxt    = state;
        fin       = 1'b0;
        jmp_en    = 1'b0;
        jmp_tgt   = operand;
        acc_we    = 1'b0;
        acc_nxt   = alu_y;
        stop_en   = 1'b0;
        stop_code = STOP_HALT;
        case (state)
            ST_FETCH: st_nxt = ST_LOAD;
            ST_LOAD:  st_nxt = ST_EXEC;
            ST_EXEC: begin
                case (op)
                    OP_BAD:  begin stop_en = 1'b1; stop_code = STOP_ILLEGAL; end
                    OP_HALT: stop_en = 1'b1;
                    OP_LDV, OP_ADD, OP_AND, OP_OR, OP_XOR, OP_EQL,
                    OP_LDVR: st_nxt = ST_DATA;
                    OP_LDIV, OP_STIV: st_nxt = ST_PTR;
                    OP_JMP, OP_CALL: begin fin = 1'b1; jmp_en = 1'b1; end
                    OP_JMN:  begin fin = 1'b1; jmp_en = acc[WORD_W-1]; end
                    OP_RET:  begin fin = 1'b1; jmp_en = 1'b1; jmp_tgt = ra[ADDR_W-1:0]; end
                    OP_LDSP: begin fin = 1'b1; acc_we = 1'b1; acc_nxt = sp; end
                    OP_LDFP: begin fin = 1'b1; acc_we = 1'b1; acc_nxt = fp; end
                    OP_LDRA: begin fin = 1'b1; acc_we = 1'b1; acc_nxt = ra; end
                    OP_LDC, OP_NOT, OP_RAR, OP_ADC: begin fin = 1'b1; acc_we = 1'b1; end
                    default: fin = 1'b1;
                endcase
            end
            ST_PTR: begin
                if (op == OP_STIV) fin = 1'b1;
                else               st_nxt = ST_DATA;
            end
            ST_DATA: begin fin = 1'b1; acc_we = 1'b1; end
            default: st_nxt = ST_STOP;
        endcase
        if (fin) begin
            if (jmp_en) st_nxt = ST_FETCH;
            else if (iar == '1) begin stop_en = 1'b1; stop_code = STOP_WRAP; end
            else st_nxt = ST_FETCH;
        end
        if (stop_en) st_nxt = ST_STOP;
    end

    // Register updates with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_FETCH;
            ir     <= '0;
            acc    <= '0;
            iar    <= '0;
            ra     <= '0;
            sp     <= '0;
            fp     <= '0;
            reason <= STOP_HALT;
        end else begin
            state <= st_nxt;
            if (state == ST_LOAD) ir <= mem_rdata;
            if (acc_we) acc <= acc_nxt;
            if (state == ST_EXEC) begin
                case (op)
                    OP_STSP: sp <= acc;
                    OP_STFP: fp <= acc;
                    OP_STRA: ra <= acc;
                    OP_CALL: ra <= {{(WORD_W-ADDR_W){1'b0}}, iar_inc};
                    default: ;
                endcase
            end
            if (fin && !stop_en) iar <= jmp_en ? jmp_tgt : iar_inc;
            if (stop_en) reason <= stop_code;
        end
    end
endmodule

// File: rtl/acc_core_chk.sv
// Module: acc_core_chk
// Temporal checks on the core's ports, attached by bind. Assumes reset is
// low at time zero and held for at least one clock edge.
module acc_core_chk #(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              halted,
    input logic [1:0]        halt_reason,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr
);
    // First cycle out of reset fetches address 0 and is running.
    assert_reset_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!halted && !mem_we && mem_addr == '0));

    // Stop flag is sticky until reset.
    assert_sticky_stop_R12: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && $stable(halt_reason)));

    // No memory writes once stopped.
    assert_quiet_when_stopped_R12: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !mem_we);

    // Reported cause is one of the three defined codes (R9, R10, R11).
    assert_reason_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halted) |-> (halt_reason != 2'd3));

    // An overflow stop leaves the instruction address at the top address.
    assert_wrap_addr_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && halt_reason == 2'd2) |-> (mem_addr == '1));
endmodule

bind acc_core acc_core_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .halted      (halted),
    .halt_reason (halt_reason),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr)
);

// File: tb/acc_core_test.sv
// Bench for acc_core: table-driven single-instruction programs, then
// directed programs for control flow, pointers, stops and reset.
module acc_core_test;
    localparam int CLK_PERIOD = 10;
    localparam int MEM_BITS   = 12;
    localparam int NV         = 13;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] mem_addr;
    logic [23:0] mem_wdata;
    logic        mem_we;
    logic [23:0] mem_rdata;
    logic        halted;
    logic [1:0]  halt_reason;

    logic [23:0] mem [1 << MEM_BITS];
    int errors = 0;
    int checks = 0;
    int late_writes = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_core uut (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_rdata(mem_rdata), .halted(halted),
        .halt_reason(halt_reason)
    );

    // Synchronous memory model, aliased on the low address bits.
    always @(posedge clk) begin
        if (mem_we === 1'b1) begin
            mem[mem_addr[MEM_BITS-1:0]] <= mem_wdata;
            if (halted === 1'b1) late_writes <= late_writes + 1;
        end
        mem_rdata <= mem[mem_addr[MEM_BITS-1:0]];
    end

    function automatic logic [23:0] mj(input logic [3:0] o, input logic [19:0] a);
        return {o, a};
    endfunction
    function automatic logic [23:0] mn(input logic [7:0] o, input logic [15:0] a);
        return {o, a};
    endfunction

    task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Hold reset and clear memory.
    task automatic prep();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        for (int i = 0; i < (1 << MEM_BITS); i++) mem[i] = '0;
    endtask

    // Release reset and wait for the core to stop.
    task automatic go(input string tag);
        rst_n = 1'b1;
        for (int c = 0; c < 600 && halted !== 1'b1; c++) @(negedge clk);
        chk({tag, " stopped"}, {23'd0, halted}, 24'd1);
    endtask

    // Fields: initial ACC, instruction under test, word at 0x101, expected ACC.
    localparam logic [95:0] VEC [NV] = '{
        {24'hFFFFFF, 24'h0ABCDE, 24'h000000, 24'h0ABCDE},
        {24'h000000, 24'h100101, 24'hABCDEF, 24'hABCDEF},
        {24'h000010, 24'h300101, 24'hFFFFFF, 24'h00000F},
        {24'hF0F0F0, 24'h400101, 24'h3C3C3C, 24'h303030},
        {24'h0F0F00, 24'h500101, 24'h300003, 24'h3F0F03},
        {24'hFF00FF, 24'h600101, 24'h0F0F0F, 24'hF00FF0},
        {24'h123456, 24'h700101, 24'h123456, 24'hFFFFFF},
        {24'h123456, 24'h700101, 24'h123457, 24'h000000},
        {24'h0F0F0F, 24'hF10000, 24'h000000, 24'hF0F0F0},
        {24'h000003, 24'hF20000, 24'h000000, 24'h800001},
        {24'h000010, 24'hFAFFFE, 24'h000000, 24'h00000E},
        {24'hFFFFFF, 24'hFA0002, 24'h000000, 24'h000001},
        {24'h000000, 24'hA00101, 24'hF00103, 24'h5A5A5A}
    };
    localparam string VTAG [NV] = '{
        "R2 ldc", "R2 ldv", "R3 add", "R3 and", "R3 or", "R3 xor",
        "R3 eql-eq", "R3 eql-ne", "R4 not", "R4 rar", "R4 adc-neg",
        "R4 adc-pos", "R8 ldiv"
    };

    initial begin
        // R1: state during reset.
        @(negedge clk);
        @(negedge clk);
        chk("R1 halted in reset", {23'd0, halted}, 24'd0);
        chk("R1 we in reset", {23'd0, mem_we}, 24'd0);
        chk("R1 addr in reset", {4'd0, mem_addr}, 24'd0);

        // Table: LDV 0x100; <instr>; STV 0x102; HALT.
        for (int v = 0; v < NV; v++) begin
            prep();
            mem[0] = mj(4'h1, 20'h00100);
            mem[1] = VEC[v][71:48];
            mem[2] = mj(4'h2, 20'h00102);
            mem[3] = mn(8'hF0, 16'h0);
            mem[12'h100] = VEC[v][95:72];
            mem[12'h101] = VEC[v][47:24];
            mem[12'h103] = 24'h5A5A5A;
            go(VTAG[v]);
            chk(VTAG[v], mem[12'h102], VEC[v][23:0]);
            chk({VTAG[v], " R9 reason"}, {22'd0, halt_reason}, 24'd0);
        end

        // R5: JMN taken and not taken.
        for (int n = 0; n < 2; n++) begin
            prep();
            mem[0] = mj(4'h1, 20'h00100);
            mem[1] = mj(4'h9, 20'h00010);
            mem[2] = mj(4'h0, 20'h00001);
            mem[3] = mj(4'h2, 20'h00102);
            mem[4] = mn(8'hF0, 16'h0);
            mem[12'h010] = mj(4'h0, 20'h00002);
            mem[12'h011] = mj(4'h8, 20'h00003);
            mem[12'h100] = (n == 0) ? 24'h800000 : 24'h7FFFFF;
            go("R5 jmn");
            chk("R5 jmn", mem[12'h102], (n == 0) ? 24'd2 : 24'd1);
        end

        // R6: CALL saves next address; LDRA, STRA, RET.
        prep();
        mem[0] = mj(4'hC, 20'h00020);
        mem[1] = mj(4'h2, 20'h00102);
        mem[2] = mj(4'h0, 20'h00040);
        mem[3] = mn(8'hF9, 16'h0);
        mem[4] = mn(8'hF3, 16'h0);
        mem[12'h020] = mn(8'hF8, 16'h0);
        mem[12'h021] = mn(8'hF3, 16'h0);
        mem[12'h040] = mj(4'h0, 20'h00009);
        mem[12'h041] = mj(4'h2, 20'h00104);
        mem[12'h042] = mn(8'hF0, 16'h0);
        go("R6 call");
        chk("R6 call return address", mem[12'h102], 24'd1);
        chk("R6 stra/ret", mem[12'h104], 24'd9);

        // R7: SP/FP moves and SP-relative access with truncation.
        prep();
        mem[0]  = mj(4'h0, 20'hFFFFF);
        mem[1]  = mn(8'hF5, 16'h0);
        mem[2]  = mj(4'h0, 20'h00077);
        mem[3]  = mj(4'hE, 20'h00302);
        mem[4]  = mj(4'hD, 20'h00207);
        mem[5]  = mj(4'h2, 20'h00102);
        mem[6]  = mn(8'hF4, 16'h0);
        mem[7]  = mj(4'h2, 20'h00104);
        mem[8]  = mj(4'h0, 20'h00003);
        mem[9]  = mn(8'hF7, 16'h0);
        mem[10] = mj(4'h0, 20'h00000);
        mem[11] = mn(8'hF6, 16'h0);
        mem[12] = mj(4'h2, 20'h00105);
        mem[13] = mn(8'hF0, 16'h0);
        mem[12'h206] = 24'h123456;
        go("R7 sp");
        chk("R7 stvr", mem[12'h301], 24'h000077);
        chk("R7 ldvr", mem[12'h102], 24'h123456);
        chk("R7 ldsp", mem[12'h104], 24'h0FFFFF);
        chk("R7 fp", mem[12'h105], 24'h000003);

        // R8: STIV ignores pointer bits 23-20.
        prep();
        mem[0] = mj(4'h0, 20'h00055);
        mem[1] = mj(4'hB, 20'h00101);
        mem[2] = mn(8'hF0, 16'h0);
        mem[12'h101] = 24'hF00300;
        go("R8 stiv");
        chk("R8 stiv", mem[12'h300], 24'h000055);

        // R10 and R12: undecodable word, then sticky and silent.
        prep();
        mem[0] = mj(4'h0, 20'h00001);
        mem[1] = mn(8'hFB, 16'h0);
        late_writes = 0;
        go("R10 illegal");
        chk("R10 reason", {22'd0, halt_reason}, 24'd1);
        repeat (20) @(negedge clk);
        chk("R12 still stopped", {23'd0, halted}, 24'd1);
        chk("R12 reason held", {22'd0, halt_reason}, 24'd1);
        chk("R12 no writes", late_writes, 24'd0);

        // R1: reset after a stop clears it.
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R1 reset clears stop", {23'd0, halted}, 24'd0);

        // R11: non-jump at top address stops with reason 2.
        prep();
        mem[0] = mj(4'h8, 20'hFFFFF);
        mem[12'hFFF] = mj(4'h0, 20'h00005);
        go("R11 wrap");
        chk("R11 reason", {22'd0, halt_reason}, 24'd2);

        // R11: jump at top address keeps running.
        prep();
        mem[0] = mj(4'h8, 20'hFFFFF);
        mem[12'hFFF] = mj(4'h8, 20'h00010);
        mem[12'h010] = mn(8'hF0, 16'h0);
        go("R11 jump at top");
        chk("R11 jump at top reason", {22'd0, halt_reason}, 24'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run is a failure.
    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule